// File: doc/BRIEF.md
# Replicated Slow-Stage Pipeline

This block is a three-stage pipeline whose middle step is a six-cycle unit that is not cut into shorter pieces. The block keeps two identical copies of that unit and sends items to them in turn, so the whole pipeline still accepts one item every three cycles. That is the rate of the three-cycle first stage. Items enter on a valid/ready stream. They pass through the three-cycle first stage and a one-cycle hand-off register, then go to copy A or copy B. A second one-cycle register gathers the results back in arrival order. A two-cycle last stage feeds a valid/ready output stream.

Each copy keeps a busy flag and a countdown. A copy takes a new item only once the merge side has collected its previous result. A stalled output therefore holds results in place all the way back to the input. The stage operations are placeholder arithmetic. A one-bit tag travels with each item and names the copy that processed it.

Top module: `twin_stage_pipe`

## Requirements
- R1: Reset is synchronous and active high. After reset, inReady is 1, outValid is 0, and the first item accepted comes out with outTag 0.
- R2: The input accepts at most one item every S1_LAT (3) cycles. When nothing downstream blocks, successive accepts under continuous inValid are exactly 3 cycles apart.
- R3: Items are numbered k from 0 in acceptance order since reset. Item k is processed by copy k mod 2 and leaves with outTag = k mod 2, where 0 means copy A and 1 means copy B.
- R4: Every accepted item leaves exactly once, in acceptance order. For the default 16-bit width, outData = b + 3, where a = inData + 0x0011 and b = (a rotated left by one bit) XOR 0x5555. All arithmetic is modulo 2^16.
- R5: With inValid and outReady held high, output handshakes in steady state are exactly 3 cycles apart.
- R6: Take an item accepted into an empty pipeline with outReady high, and call the accepting clock edge edge 0. Its output handshake happens at edge 13 (3 + 1 + 6 + 1 + 2).
- R7: While outValid is 1 and outReady is 0, the next cycle still shows outValid 1, with outData and outTag unchanged.
- R8: With outReady held at 0 and inValid held high, an empty pipeline accepts exactly 6 items, after which inReady stays 0. Once outReady is raised, all 6 leave in order with correct values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input item offered |
| inReady | output | 1 | Pipeline can take an item this cycle |
| inData | input | DATA_W | Input item value |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Consumer takes the result this cycle |
| outData | output | DATA_W | Result value |
| outTag | output | 1 | Copy that processed the item (0 = A, 1 = B) |

## Verification
A dispatch or merge pointer that falls out of step shows first as a wrong outTag, and usually a wrong outData, on the next result. That result appears within about thirteen cycles of the faulty steering. A busy flag that clears too early lets a copy take a new item over an unmerged one. The stalled-output test exposes this as a lost or duplicated result when the pipeline drains. A counter loaded with the wrong value shifts the single-item latency or breaks the three-cycle output spacing. Both are measured edge by edge.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

  localparam int NUM_COPIES = 2;

  // Strobes from control to datapath, one per register load.
  typedef struct packed {
    logic                  s1Load;    // capture input into stage 1
    logic                  s1Leave;   // stage 1 result to hand-off register
    logic [NUM_COPIES-1:0] copyLoad;  // hand-off register into copy A or B
    logic                  mergeTake; // copy result into merge register
    logic                  mergeSel;  // which copy the merge reads
    logic                  s3Load;    // merge register into stage 3
  } tsp_strobe_t;

  function automatic int cntWidth(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    m = (m > c) ? m : c;
    return $clog2(m + 1);
  endfunction

endpackage

// File: rtl/tsp_timer.sv
module tsp_timer #(
  parameter int LAT   = 3,
  parameter int CNT_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic leave,
  output logic busy,
  output logic done
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(LAT - 1);

  logic [CNT_W-1:0] cnt;

  // Load wins over leave, so a unit can be refilled in the cycle it empties.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= LOAD_VAL;
    end else begin
      if (leave) busy <= 1'b0;
      if (busy && cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);
endmodule

// File: rtl/tsp_ctrl.sv
module tsp_ctrl
  import tsp_pkg::*;
#(
  parameter int S1_LAT  = 3,
  parameter int MID_LAT = 6,
  parameter int S3_LAT  = 2,
  parameter int CNT_W   = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output logic        inReady,
  output logic        outValid,
  input  logic        outReady,
  output tsp_strobe_t strb
);
  logic s1Busy, s1Done, s1Leave, s1Load;
  logic s3Busy, s3Done, s3Leave, s3Free;
  logic buf1Full, buf1Leave, buf1Free;
  logic buf2Full, buf2Leave, buf2Free;
  logic dispPtr, mergePtr, mergeTake;
  logic [NUM_COPIES-1:0] copyBusy, copyDone, copyFree, copyLeave, copyLoad;

  // Ready chain runs from the output back to the input.
  assign s3Leave   = s3Done && outReady;
  assign s3Free    = !s3Busy || s3Leave;
  assign buf2Leave = buf2Full && s3Free;
  assign buf2Free  = !buf2Full || buf2Leave;
  assign mergeTake = copyDone[mergePtr] && buf2Free;
  assign buf1Leave = buf1Full && copyFree[dispPtr];
  assign buf1Free  = !buf1Full || buf1Leave;
  assign s1Leave   = s1Done && buf1Free;
  assign inReady   = !s1Busy || s1Leave;
  assign s1Load    = inValid && inReady;
  assign outValid  = s3Done;

  tsp_timer #(.LAT(S1_LAT), .CNT_W(CNT_W)) u_s1Timer (
    .clk(clk), .rst(rst), .load(s1Load), .leave(s1Leave),
    .busy(s1Busy), .done(s1Done)
  );

  for (genvar g = 0; g < NUM_COPIES; g++) begin : g_copy
    assign copyLeave[g] = mergeTake && (mergePtr == 1'(g));
    assign copyFree[g]  = !copyBusy[g] || copyLeave[g];
    assign copyLoad[g]  = buf1Leave && (dispPtr == 1'(g));

    tsp_timer #(.LAT(MID_LAT), .CNT_W(CNT_W)) u_midTimer (
      .clk(clk), .rst(rst), .load(copyLoad[g]), .leave(copyLeave[g]),
      .busy(copyBusy[g]), .done(copyDone[g])
    );
  end

  tsp_timer #(.LAT(S3_LAT), .CNT_W(CNT_W)) u_s3Timer (
    .clk(clk), .rst(rst), .load(buf2Leave), .leave(s3Leave),
    .busy(s3Busy), .done(s3Done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      buf1Full <= 1'b0;
      buf2Full <= 1'b0;
      dispPtr  <= 1'b0;
      mergePtr <= 1'b0;
    end else begin
      if (s1Leave)        buf1Full <= 1'b1;
      else if (buf1Leave) buf1Full <= 1'b0;
      if (mergeTake)      buf2Full <= 1'b1;
      else if (buf2Leave) buf2Full <= 1'b0;
      if (buf1Leave) dispPtr  <= ~dispPtr;
      if (mergeTake) mergePtr <= ~mergePtr;
    end
  end

  always_comb begin
    strb.s1Load    = s1Load;
    strb.s1Leave   = s1Leave;
    strb.copyLoad  = copyLoad;
    strb.mergeTake = mergeTake;
    strb.mergeSel  = mergePtr;
    strb.s3Load    = buf2Leave;
  end
endmodule

// File: rtl/tsp_datapath.sv
module tsp_datapath
  import tsp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  tsp_strobe_t       strb,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData,
  output logic              outTag
);
  localparam logic [DATA_W-1:0] ADD_IN  = DATA_W'(17);
  localparam logic [DATA_W-1:0] MIX_PAT = {(DATA_W/2){2'b01}};
  localparam logic [DATA_W-1:0] ADD_OUT = DATA_W'(3);

  logic [DATA_W-1:0] s1Data, buf1Data, buf2Data, s3Data;
  logic [NUM_COPIES-1:0][DATA_W-1:0] copyData;
  logic buf2Tag, s3Tag;

  function automatic logic [DATA_W-1:0] midOp(input logic [DATA_W-1:0] x);
    return {x[DATA_W-2:0], x[DATA_W-1]} ^ MIX_PAT;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Data   <= '0;
      buf1Data <= '0;
      copyData <= '0;
      buf2Data <= '0;
      buf2Tag  <= 1'b0;
      s3Data   <= '0;
      s3Tag    <= 1'b0;
    end else begin
      if (strb.s1Load)  s1Data   <= inData + ADD_IN;
      if (strb.s1Leave) buf1Data <= s1Data;
      for (int i = 0; i < NUM_COPIES; i++)
        if (strb.copyLoad[i]) copyData[i] <= midOp(buf1Data);
      if (strb.mergeTake) begin
        buf2Data <= copyData[strb.mergeSel];
        buf2Tag  <= strb.mergeSel;
      end
      if (strb.s3Load) begin
        s3Data <= buf2Data + ADD_OUT;
        s3Tag  <= buf2Tag;
      end
    end
  end

  assign outData = s3Data;
  assign outTag  = s3Tag;
endmodule

// File: rtl/twin_stage_pipe.sv
module twin_stage_pipe
  import tsp_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int S1_LAT  = 3,
  parameter int MID_LAT = 6,
  parameter int S3_LAT  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              outTag
);
  localparam int CNT_W = cntWidth(S1_LAT, MID_LAT, S3_LAT);

  tsp_strobe_t strb;

  tsp_ctrl #(
    .S1_LAT(S1_LAT), .MID_LAT(MID_LAT), .S3_LAT(S3_LAT), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .strb(strb)
  );

  tsp_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .inData(inData),
    .outData(outData), .outTag(outTag)
  );
endmodule

// File: rtl/twin_stage_pipe_chk.sv
module twin_stage_pipe_chk
  import tsp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int S1_LAT = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic              outTag,
  input tsp_strobe_t       strb
);
  int   gap;
  logic seenIn, seenOut, lastTag;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap     <= 0;
      seenIn  <= 1'b0;
      seenOut <= 1'b0;
      lastTag <= 1'b0;
    end else begin
      if (inValid && inReady) begin
        gap    <= 1;
        seenIn <= 1'b1;
      end else if (gap < S1_LAT) begin
        gap <= gap + 1;
      end
      if (outValid && outReady) begin
        seenOut <= 1'b1;
        lastTag <= outTag;
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!outValid && inReady)); // R1

  AST_IN_SPACING: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && seenIn) |-> (gap >= S1_LAT)); // R2

  AST_TAG_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady) |-> (seenOut ? (outTag != lastTag) : (outTag == 1'b0))); // R3

  AST_ONE_DISPATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb.copyLoad)); // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outTag))); // R7
endmodule

bind twin_stage_pipe twin_stage_pipe_chk #(.DATA_W(DATA_W), .S1_LAT(S1_LAT)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outData(outData),
  .outTag(outTag), .strb(strb)
);

// File: tb/tb_twin_stage_pipe.sv
module tb_twin_stage_pipe;
  localparam int W = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic         outReady = 1'b0;
  logic [W-1:0] inData = '0;
  wire          inReady, outValid, outTag;
  wire  [W-1:0] outData;

  twin_stage_pipe dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outTag(outTag)
  );

  int checks = 0, errors = 0, cycle = 0;
  bit finished = 1'b0;
  always @(posedge clk) cycle <= cycle + 1;

  logic [W:0] expQ[$];
  int acceptCnt;
  bit gotIn, gotOut, prevStall;
  int inEdge, outEdge;
  logic [W-1:0] prevData;
  logic prevTag;

  function automatic logic [W-1:0] expOf(input logic [W-1:0] x);
    logic [W-1:0] a, b;
    a = x + 16'h0011;
    b = {a[W-2:0], a[W-1]} ^ 16'h5555;
    return b + 16'h0003;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0; outReady = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expQ.delete();
    acceptCnt = 0;
    prevStall = 1'b0;
    #1;
    chk(inReady == 1'b1, "R1 inReady after reset", inReady, 1);
    chk(outValid == 1'b0, "R1 outValid after reset", outValid, 0);
  endtask

  // Drive at the falling edge, sample just before the next rising edge.
  task automatic step(input logic v, input logic [W-1:0] d, input logic r);
    logic [W:0] e;
    @(negedge clk);
    inValid = v; inData = d; outReady = r;
    #1;
    gotIn = 1'b0; gotOut = 1'b0;
    if (prevStall)
      chk(outValid && outData == prevData && outTag == prevTag, "R7 held output",
          {outValid, outTag, outData}, {1'b1, prevTag, prevData});
    prevStall = outValid && !outReady;
    prevData  = outData;
    prevTag   = outTag;
    if (outValid && outReady) begin
      gotOut = 1'b1; outEdge = cycle;
      if (expQ.size() == 0) begin
        chk(1'b0, "R4 unexpected output", outData, 0);
      end else begin
        e = expQ.pop_front();
        chk(outData == e[W-1:0], "R4 data/order", outData, e[W-1:0]);
        chk(outTag == e[W], "R3 tag", outTag, e[W]);
      end
    end
    if (inValid && inReady) begin
      gotIn = 1'b1; inEdge = cycle;
      expQ.push_back({1'(acceptCnt), expOf(d)});
      acceptCnt++;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && expQ.size() != 0; i++) step(1'b0, '0, 1'b1);
    chk(expQ.size() == 0, "R4 all items delivered", expQ.size(), 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_2417));
    doReset();

    // R6: single item latency, R1 first tag
    begin
      int accAt, outAt;
      accAt = -1; outAt = -1;
      step(1'b1, 16'h1234, 1'b1);
      if (gotIn) accAt = inEdge;
      for (int i = 0; i < 40 && outAt < 0; i++) begin
        step(1'b0, '0, 1'b1);
        if (gotOut) outAt = outEdge;
      end
      chk(accAt >= 0, "R1 first item accepted", accAt, 0);
      chk(outAt - accAt == 13, "R6 latency", outAt - accAt, 13);
    end

    // R2, R5: full rate streaming
    doReset();
    begin
      int lastIn, lastOut, outs;
      lastIn = -1; lastOut = -1; outs = 0;
      for (int i = 0; i < 60; i++) begin
        step(1'b1, 16'($urandom), 1'b1);
        if (gotIn) begin
          if (lastIn >= 0) chk(inEdge - lastIn == 3, "R2 accept spacing", inEdge - lastIn, 3);
          lastIn = inEdge;
        end
        if (gotOut) begin
          if (lastOut >= 0) chk(outEdge - lastOut == 3, "R5 output spacing", outEdge - lastOut, 3);
          lastOut = outEdge; outs++;
        end
      end
      chk(outs >= 10, "R5 outputs seen", outs, 10);
      drain();
    end

    // R8: blocked output fills the pipeline
    doReset();
    begin
      for (int i = 0; i < 60; i++) step(1'b1, 16'(16'hA000 + i), 1'b0);
      chk(acceptCnt == 6, "R8 capacity", acceptCnt, 6);
      chk(inReady == 1'b0, "R8 inReady low when full", inReady, 0);
      chk(outValid == 1'b1, "R8 output waiting", outValid, 1);
      drain();
    end

    // Random valid/ready traffic with edge data values
    doReset();
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] d;
      case ($urandom_range(0, 7))
        0: d = 16'hFFFF;
        1: d = 16'hFFEE;
        2: d = 16'h0000;
        default: d = 16'($urandom);
      endcase
      step($urandom_range(0, 9) < 6, d, $urandom_range(0, 9) < 7);
    end
    drain();

    // Reset in the middle of traffic discards everything
    for (int i = 0; i < 20; i++) step(1'b1, 16'($urandom), 1'b0);
    doReset();
    begin
      int outAt;
      outAt = -1;
      step(1'b1, 16'h00FF, 1'b1);
      for (int i = 0; i < 40 && outAt < 0; i++) begin
        step(1'b0, '0, 1'b1);
        if (gotOut) outAt = outEdge;
      end
      chk(outAt >= 0, "R1 output after mid-run reset", outAt, 0);
    end
    drain();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule